// File: doc/BRIEF.md
# Bitfield Move Execution Unit

This unit executes the bitfield-move instruction group of a 64-bit integer pipeline. It handles signed extract, field insert and unsigned extract. Each cycle in which `in_valid` is high, it decodes the 32-bit instruction word and takes the source operand and the current value of the destination register. One cycle later it presents the value to write back, the destination register index, a write enable, and a flag for a reserved encoding.

All three variants share a single mask-and-shift path. The low `imms+1` bits of the source are isolated. When `imms >= immr`, they are moved down by `immr`. Otherwise they are moved up by `width - immr`. The variants differ only in what goes around the moved field: copies of the field's top bit for signed extract, the old destination bits for insert, and zeros for unsigned extract. In 32-bit operation, the upper half of the result is always zero.

The unit sits between operand read and write-back. The register file, fetch and the routing of instructions to this unit lie outside it.

Top module: `bfx_unit`

## Requirements
- R1: Instruction bit 31 selects the width (0 = 32-bit, 1 = 64-bit). Bits 30:29 are the opcode, bit 22 is the N bit, bits 21:16 are the rotate amount `immr`, and bits 15:10 are the field top `imms`.
- R2: A 64-bit instruction with N = 0 is reserved.
- R3: A 32-bit instruction is reserved if N = 1, if bit 5 of `immr` is 1, or if bit 5 of `imms` is 1.
- R4: Opcode 3 is reserved.
- R5: For a reserved encoding, the unit produces `out_valid`=1, `out_illegal`=1, `out_wr_en`=0 and `out_result`=0.
- R6: Outputs are registered one cycle after `in_valid`. In a cycle after `in_valid` was low, `out_valid`, `out_wr_en` and `out_illegal` are all low. After reset, all outputs are zero.
- R7: Opcode 2 (unsigned extract) returns the moved field with every other bit zero. This holds for both the downward move (`imms >= immr`) and the upward move (`imms < immr`).
- R8: Opcode 0 (signed extract) returns the moved field, and sets every bit above the field's top bit when that bit is 1. A field whose top bit is already bit 63 gets no fill.
- R9: Opcode 1 (insert) replaces only the destination bits covered by the moved mask. All other bits of `in_dst` pass through unchanged. This includes the case `imms = immr`.
- R10: In 32-bit operation, bits 63:32 of the result are zero. This holds for every opcode, including a sign fill from bit 31.
- R11: With `imms` = 63, the field is the whole 64-bit source.
- R12: `out_rd` equals instruction bits 4:0 of the accepted instruction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Instruction and operands are valid this cycle |
| in_insn | input | 32 | Instruction word |
| in_src | input | 64 | Source register value |
| in_dst | input | 64 | Current destination register value |
| out_valid | output | 1 | A result is present |
| out_rd | output | 5 | Destination register index |
| out_result | output | 64 | Value to write back |
| out_wr_en | output | 1 | Write the result to the register file |
| out_illegal | output | 1 | The accepted instruction was a reserved encoding |

## Verification
The embedded properties hold on every cycle for the following behaviours:
- the one-cycle valid timing;
- the exclusive pairing of write enable and illegal flag on each result;
- the zero result on reserved encodings;
- the illegal flag for opcode 3 and for the width-dependent reserved rules;
- the zero upper half after any 32-bit instruction.

Only the bench's scenarios can show that the values computed are correct. These are field placement, sign fill, insert merge and the boundaries `imms = immr`, `imms = 63`, `immr = 0` and a sign bit at 31 or 63. The bench checks them against a bit-by-bit model, using directed and pseudo-random instructions.

// File: rtl/bfx_pkg.sv
package bfx_pkg;
    localparam int INSN_W  = 32;
    localparam int IMM_W   = 6;
    localparam int RIDX_W  = 5;

    typedef enum logic [1:0] {
        OP_SEXT = 2'd0,
        OP_INS  = 2'd1,
        OP_ZEXT = 2'd2,
        OP_RSVD = 2'd3
    } bfx_op_e;

    typedef struct packed {
        logic               wide;
        bfx_op_e            op;
        logic [IMM_W-1:0]   rot;
        logic [IMM_W-1:0]   top;
        logic [RIDX_W-1:0]  rd;
    } bfx_dec_t;
endpackage

// File: rtl/bfx_decode.sv
module bfx_decode
    import bfx_pkg::*;
(
    input  logic [INSN_W-1:0] insn,
    output bfx_dec_t          dec,
    output logic              illegal
);
    logic nbit;

    always_comb begin
        dec.wide = insn[31];
        dec.op   = bfx_op_e'(insn[30:29]);
        dec.rot  = insn[21:16];
        dec.top  = insn[15:10];
        dec.rd   = insn[4:0];
        nbit     = insn[22];
        if (dec.op == OP_RSVD)
            illegal = 1'b1;
        else if (dec.wide)
            illegal = !nbit;
        else
            illegal = nbit | dec.rot[IMM_W-1] | dec.top[IMM_W-1];
    end
endmodule

// File: rtl/bfx_field.sv
module bfx_field
    import bfx_pkg::*;
#(
    parameter int DATA_W = 64
) (
    input  bfx_dec_t          dec,
    input  logic [DATA_W-1:0] src,
    input  logic [DATA_W-1:0] dst,
    output logic [DATA_W-1:0] result
);
    localparam int SH_W   = $clog2(DATA_W);
    localparam int POS_W  = SH_W + 2;
    localparam int HALF_W = DATA_W / 2;
    localparam logic [DATA_W-1:0] ONE  = DATA_W'(1);
    localparam logic [DATA_W-1:0] LOWH = {{HALF_W{1'b0}}, {HALF_W{1'b1}}};

    logic [POS_W-1:0]  width_v;
    logic [POS_W-1:0]  sbpos;
    logic [POS_W-1:0]  lsh;
    logic [DATA_W-1:0] fmask;
    logic [DATA_W-1:0] tmask;
    logic [DATA_W-1:0] moved;
    logic [DATA_W-1:0] fill;
    logic              sbit;
    logic [DATA_W-1:0] raw;

    always_comb begin
        width_v = dec.wide ? POS_W'(DATA_W) : POS_W'(HALF_W);
        lsh     = width_v - POS_W'(dec.rot);
        if (dec.top == {SH_W{1'b1}})
            fmask = '1;
        else
            fmask = (ONE << (POS_W'(dec.top) + POS_W'(1))) - ONE;

        if (dec.top < dec.rot) begin
            moved = (src & fmask) << lsh;
            tmask = fmask << lsh;
            sbpos = width_v + POS_W'(dec.top) - POS_W'(dec.rot);
            if (sbpos == POS_W'(DATA_W - 1))
                fill = '0;
            else
                fill = ~((ONE << (sbpos + POS_W'(1))) - ONE);
        end else begin
            moved = (src & fmask) >> dec.rot;
            tmask = fmask >> dec.rot;
            sbpos = POS_W'(dec.top) - POS_W'(dec.rot);
            fill  = ~tmask;
        end

        if (!dec.wide)
            moved = moved & LOWH;

        sbit = moved[sbpos[SH_W-1:0]];

        unique case (dec.op)
            OP_SEXT: raw = sbit ? (moved | fill) : moved;
            OP_INS:  raw = (dst & ~tmask) | moved;
            OP_ZEXT: raw = moved;
            default: raw = '0;
        endcase

        result = dec.wide ? raw : (raw & LOWH);
    end
endmodule

// File: rtl/bfx_unit.sv
module bfx_unit
    import bfx_pkg::*;
#(
    parameter int DATA_W = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [31:0]       in_insn,
    input  logic [DATA_W-1:0] in_src,
    input  logic [DATA_W-1:0] in_dst,
    output logic              out_valid,
    output logic [4:0]        out_rd,
    output logic [DATA_W-1:0] out_result,
    output logic              out_wr_en,
    output logic              out_illegal
);
    localparam int HALF_W = DATA_W / 2;

    bfx_dec_t          dec;
    logic              ill;
    logic [DATA_W-1:0] res_c;

    bfx_decode u_dec (
        .insn    (in_insn),
        .dec     (dec),
        .illegal (ill)
    );

    bfx_field #(.DATA_W(DATA_W)) u_field (
        .dec    (dec),
        .src    (in_src),
        .dst    (in_dst),
        .result (res_c)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid   <= 1'b0;
            out_wr_en   <= 1'b0;
            out_illegal <= 1'b0;
            out_rd      <= '0;
            out_result  <= '0;
        end else begin
            out_valid   <= in_valid;
            out_wr_en   <= in_valid & ~ill;
            out_illegal <= in_valid & ill;
            if (in_valid) begin
                out_rd     <= dec.rd;
                out_result <= ill ? '0 : res_c;
            end
        end
    end

    // R6: one-cycle latency of the valid strobe
    a_r6_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
    a_r6_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> (!out_valid && !out_wr_en && !out_illegal));
    // R5: a result either writes or is flagged, never both
    a_r5_write_xor_illegal: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_wr_en ^ out_illegal));
    a_r5_illegal_zero: assert property (@(posedge clk) disable iff (!rst_n)
        out_illegal |-> (out_result == '0 && !out_wr_en));
    // R4: opcode 3 is always reserved
    a_r4_opc3_flag: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_insn[30:29] == 2'd3) |=> out_illegal);
    // R2: wide form needs the N bit
    a_r2_wide_n: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_insn[31] && !in_insn[22]) |=> out_illegal);
    // R3: narrow form rejects N and any high immediate bit
    a_r3_narrow_rsvd: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !in_insn[31] && (in_insn[22] || in_insn[21] || in_insn[15]))
        |=> out_illegal);
    // R10: narrow results have a zero upper half
    a_r10_upper_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !in_insn[31]) |=> (out_result[DATA_W-1:HALF_W] == '0));
endmodule

// File: tb/bfx_unit_tb.sv
module bfx_unit_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [31:0] in_insn = '0;
    logic [63:0] in_src = '0;
    logic [63:0] in_dst = '0;
    logic        out_valid;
    logic [4:0]  out_rd;
    logic [63:0] out_result;
    logic        out_wr_en;
    logic        out_illegal;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    typedef struct {
        logic [4:0]  rd;
        logic [63:0] res;
        logic        wr;
        logic        ill;
        string       tag;
    } exp_t;

    exp_t exp_q[$];

    always #5 clk = ~clk;

    bfx_unit u_dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_insn(in_insn),
        .in_src(in_src), .in_dst(in_dst), .out_valid(out_valid), .out_rd(out_rd),
        .out_result(out_result), .out_wr_en(out_wr_en), .out_illegal(out_illegal)
    );

    function automatic logic [31:0] mk(bit sf, int op, bit n, int rot, int top, int rd);
        return {sf, 2'(op), 6'b100110, n, 6'(rot), 6'(top), 5'd3, 5'(rd)};
    endfunction

    function automatic exp_t ref_model(logic [31:0] insn, logic [63:0] s, logic [63:0] d);
        exp_t r;
        bit wide = insn[31];
        int op   = int'(insn[30:29]);
        bit n    = insn[22];
        int rot  = int'(insn[21:16]);
        int top  = int'(insn[15:10]);
        int w    = wide ? 64 : 32;
        int sb;
        logic [63:0] val = '0;
        logic [63:0] cov = '0;
        r.rd  = insn[4:0];
        r.tag = "";
        if (op == 3 || (wide && !n) || (!wide && (n || rot >= 32 || top >= 32))) begin
            r.res = '0; r.wr = 1'b0; r.ill = 1'b1;
            return r;
        end
        if (top >= rot) begin
            for (int i = 0; i <= top - rot; i++) begin
                val[i] = s[rot + i]; cov[i] = 1'b1;
            end
            sb = top - rot;
        end else begin
            for (int i = 0; i <= top; i++) begin
                if (w - rot + i < 64) begin
                    val[w - rot + i] = s[i]; cov[w - rot + i] = 1'b1;
                end
            end
            sb = w - rot + top;
        end
        if (op == 0 && val[sb]) begin
            for (int j = sb + 1; j < 64; j++) val[j] = 1'b1;
        end
        if (op == 1) begin
            for (int j = 0; j < 64; j++) if (!cov[j]) val[j] = d[j];
        end
        if (!wide) val[63:32] = '0;
        r.res = val; r.wr = 1'b1; r.ill = 1'b0;
        return r;
    endfunction

    task automatic drive(input logic [31:0] insn, input logic [63:0] s,
                         input logic [63:0] d, input string tag);
        exp_t e;
        e = ref_model(insn, s, d);
        e.tag = tag;
        exp_q.push_back(e);
        in_insn = insn; in_src = s; in_dst = d; in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic summary();
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    endtask

    // Monitor: pops the scoreboard as results appear
    always @(negedge clk) begin
        if (rst_n && out_valid) begin
            n_tests++;
            if (exp_q.size() == 0) begin
                n_fail++;
                $display("FAIL R6 unexpected out_valid: actual 1 expected 0");
            end else begin
                exp_t e;
                e = exp_q.pop_front();
                if (out_rd !== e.rd || out_result !== e.res ||
                    out_wr_en !== e.wr || out_illegal !== e.ill) begin
                    n_fail++;
                    $display("FAIL %s R12: actual rd=%0d res=%h wr=%b ill=%b expected rd=%0d res=%h wr=%b ill=%b",
                             e.tag, out_rd, out_result, out_wr_en, out_illegal,
                             e.rd, e.res, e.wr, e.ill);
                end
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL R6 watchdog expired: actual hung expected finished");
            summary();
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        n_tests++;   // R6 reset state
        if (out_valid !== 1'b0 || out_wr_en !== 1'b0 || out_illegal !== 1'b0 || out_result !== '0) begin
            n_fail++;
            $display("FAIL R6 reset: actual v=%b wr=%b ill=%b res=%h expected zeros",
                     out_valid, out_wr_en, out_illegal, out_result);
        end
        rst_n = 1'b1;
        @(negedge clk);

        // R7 unsigned extract, downward and upward
        drive(mk(1, 2, 1, 8, 15, 17), 64'h0123_4567_89ab_cdef, 64'h0, "R7");
        drive(mk(1, 2, 1, 60, 3, 2), 64'hffff_ffff_ffff_fffa, 64'h0, "R7");
        drive(mk(1, 2, 1, 0, 0, 31), 64'h1, 64'h0, "R7");
        // R8 signed extract, both sign values and a top at bit 63
        drive(mk(1, 0, 1, 4, 11, 5), 64'h0000_0000_0000_0f80, 64'h0, "R8");
        drive(mk(1, 0, 1, 4, 11, 6), 64'h0000_0000_0000_0780, 64'h0, "R8");
        drive(mk(1, 0, 1, 63, 62, 7), 64'h4000_0000_0000_0001, 64'h0, "R8");
        drive(mk(1, 0, 1, 40, 7, 8), 64'h0000_0000_0000_0080, 64'h0, "R8");
        // R9 insert, upward and imms = immr
        drive(mk(1, 1, 1, 52, 7, 9), 64'h0000_0000_0000_00a5, 64'hdead_beef_cafe_f00d, "R9");
        drive(mk(1, 1, 1, 5, 5, 10), 64'h0000_0000_0000_0020, 64'hffff_ffff_ffff_fffe, "R9");
        // R11 whole-register field
        drive(mk(1, 2, 1, 0, 63, 11), 64'h8765_4321_0fed_cba9, 64'h0, "R11");
        drive(mk(1, 0, 1, 0, 63, 12), 64'h8765_4321_0fed_cba9, 64'h0, "R11");
        // R10 narrow operation with bit 31 set
        drive(mk(0, 2, 0, 0, 31, 13), 64'hffff_ffff_8000_0001, 64'h0, "R10");
        drive(mk(0, 0, 0, 24, 31, 14), 64'h1234_5678_9abc_def0, 64'h0, "R10");
        drive(mk(0, 1, 0, 28, 3, 15), 64'h0000_0000_0000_000f, 64'hffff_ffff_0000_0000, "R10");
        drive(mk(0, 0, 0, 0, 31, 16), 64'h0000_0000_8000_0000, 64'h0, "R10");
        // R2 / R3 / R4 / R5 reserved encodings
        drive(mk(1, 2, 0, 3, 9, 18), 64'hffff, 64'h1, "R2");
        drive(mk(0, 2, 1, 3, 9, 19), 64'hffff, 64'h1, "R3");
        drive(mk(0, 2, 0, 33, 9, 20), 64'hffff, 64'h1, "R3");
        drive(mk(0, 2, 0, 3, 40, 21), 64'hffff, 64'h1, "R3");
        drive(mk(1, 3, 1, 3, 9, 22), 64'hffff, 64'h1, "R4");
        drive(mk(0, 3, 0, 3, 9, 23), 64'hffff, 64'h1, "R5");

        // R6 idle gap
        @(negedge clk);
        @(negedge clk);
        n_tests++;
        if (out_valid !== 1'b0 || out_wr_en !== 1'b0 || out_illegal !== 1'b0) begin
            n_fail++;
            $display("FAIL R6 idle: actual v=%b wr=%b ill=%b expected 0 0 0",
                     out_valid, out_wr_en, out_illegal);
        end

        // R1 pseudo-random legal mix, back to back
        for (int k = 0; k < 300; k++) begin
            bit sf;
            int op, rot, top;
            logic [63:0] s, d;
            sf  = 1'($urandom);
            op  = int'($urandom % 3);
            rot = int'($urandom % (sf ? 64 : 32));
            top = int'($urandom % (sf ? 64 : 32));
            s   = {$urandom, $urandom};
            d   = {$urandom, $urandom};
            drive(mk(sf, op, sf, rot, top, k % 32), s, d, "R1");
        end

        repeat (3) @(negedge clk);
        n_tests++;
        if (exp_q.size() != 0) begin
            n_fail++;
            $display("FAIL R6 missing results: actual %0d pending expected 0", exp_q.size());
        end
        done = 1'b1;
        summary();
    end
endmodule